// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Link

This block joins two processor cores with two one-way word queues. Each queue is 8 words deep and 32 bits wide. A word that core A pushes into its outgoing queue comes out of core B's incoming side, and the other queue carries words from B to A in the same way. Each core reaches the block through its own small register port. That port decodes three addresses: a status word, an outgoing-data register that can only be written, and an incoming-data register that can only be read.

The status word mixes two kinds of bit. Two bits are live: one shows that incoming data is available, the other shows that the outgoing queue has space. Two bits are sticky error flags: one records a push attempted against a full outgoing queue, the other records a pop attempted against an empty incoming queue. Each core also has an interrupt-request output. It is raised while that core has incoming data waiting or either of its error flags is set, so the receiving core can sleep until it is woken.

A register access takes one clock. Read data appears on the port's read-data output in the following cycle. A write to the status word is how a core acknowledges its errors.

Top module: `mbox_pair`

## Requirements
- R1: After a synchronous reset the status word of each core reads 4'b0010 (bit 1 = 1, bits 0, 2 and 3 = 0), both interrupt outputs are low and both queues are empty.
- R2: Port addresses: 0 = status, 1 = outgoing data (write only), 2 = incoming data (read only). A read issued in cycle t returns its value on the read-data output in cycle t+1. The read-data output is 0 in every other cycle, and for reads of address 1 or 3. A write to address 2 or 3 has no effect.
- R3: Words pushed by one core are popped by the other core in the order they were pushed. Each queue holds up to 8 words.
- R4: Status bit 0 is 1 exactly when the core's incoming queue is not empty.
- R5: Status bit 1 is 1 exactly when the core's outgoing queue is not full. It reads 0 after 8 unread pushes.
- R6: A push to a full outgoing queue is dropped and leaves the queue contents unchanged. It also sets status bit 2, which stays set until it is cleared.
- R7: A pop from an empty incoming queue returns 0 and leaves the queue unchanged. It also sets status bit 3, which stays set until it is cleared.
- R8: Any write to address 0 clears both sticky bits (2 and 3) of the writing core only.
- R9: A core's interrupt output is high in cycle t+1 exactly when, in cycle t, that core's status bit 0, 2 or 3 was set.
- R10: The two directions run independently. Both cores may access their ports in the same cycle, and one core may pop a queue in the same cycle the other pushes to it.
- R11: Full and empty are judged on the state before the clock edge. A push to a full queue is dropped even if the other core pops that queue in the same cycle. A pop from an empty queue returns 0 and sets bit 3 even if the other core pushes to that queue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Core A access strobe |
| a_we | input | 1 | Core A write (1) / read (0) |
| a_addr | input | 2 | Core A register address |
| a_wdata | input | 32 | Core A write data |
| a_rdata | output | 32 | Core A read data, one cycle after the read |
| a_irq | output | 1 | Core A interrupt request |
| b_req | input | 1 | Core B access strobe |
| b_we | input | 1 | Core B write (1) / read (0) |
| b_addr | input | 2 | Core B register address |
| b_wdata | input | 32 | Core B write data |
| b_rdata | output | 32 | Core B read data, one cycle after the read |
| b_irq | output | 1 | Core B interrupt request |

## Verification
The hardest situations to reach are the edge collisions of R11: one core pushes while the other pops the same queue, and that queue is exactly full or exactly empty. No single-port sequence produces them. The stimulus first fills the A-to-B queue with 8 words and then issues an A push and a B pop in the same cycle. It then drains the queue and issues the pair again against the empty queue. A long phase of mixed, biased random traffic on both ports then revisits these boundaries, and a queue-based model compared on every clock checks each result.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // register port address map
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_TXD  = 2'd1,
    REG_RXD  = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  // read-data source chosen for the cycle after an access
  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_STAT = 2'd1,
    RSEL_FIFO = 2'd2
  } rsel_e;

  // status word, bit 3 down to bit 0
  typedef struct packed {
    logic rx_err;    // bit 3: sticky, pop while empty
    logic tx_err;    // bit 2: sticky, push while full
    logic tx_space;  // bit 1: outgoing queue not full
    logic rx_avail;  // bit 0: incoming queue not empty
  } mbox_stat_t;

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic             full,
  output logic             empty,
  output logic [WIDTH-1:0] q,
  output logic [LW-1:0]    level
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    rptr;
  logic             push_ok;
  logic             pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  // storage: synchronous write, registered read (block RAM friendly)
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
    q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             tx_full,
  input  logic             rx_empty,
  input  logic [WIDTH-1:0] rx_q,
  output logic             tx_push,
  output logic [WIDTH-1:0] tx_data,
  output logic             rx_pop,
  output logic [WIDTH-1:0] rdata,
  output logic             irq,
  output logic             wof,
  output logic             roe,
  output logic             stat_clr
);

  reg_addr_e  addr_e;
  rsel_e      rsel_q;
  mbox_stat_t stat_now;
  mbox_stat_t stat_rd_q;
  logic       rd_acc;

  assign addr_e   = reg_addr_e'(addr);
  assign rd_acc   = req & ~we;
  assign tx_push  = req & we & (addr_e == REG_TXD);
  assign tx_data  = wdata;
  assign rx_pop   = rd_acc & (addr_e == REG_RXD);
  assign stat_clr = req & we & (addr_e == REG_STAT);

  assign stat_now = '{rx_err: roe, tx_err: wof, tx_space: ~tx_full, rx_avail: ~rx_empty};

  // sticky error flags
  always_ff @(posedge clk) begin
    if (rst) begin
      wof <= 1'b0;
      roe <= 1'b0;
    end else if (stat_clr) begin
      wof <= 1'b0;
      roe <= 1'b0;
    end else begin
      if (tx_push & tx_full) wof <= 1'b1;
      if (rx_pop & rx_empty) roe <= 1'b1;
    end
  end

  // read path select and status capture, interrupt register
  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q    <= RSEL_ZERO;
      stat_rd_q <= '0;
      irq       <= 1'b0;
    end else begin
      irq    <= stat_now.rx_avail | wof | roe;
      rsel_q <= RSEL_ZERO;
      if (rd_acc) begin
        case (addr_e)
          REG_STAT: begin
            rsel_q    <= RSEL_STAT;
            stat_rd_q <= stat_now;
          end
          REG_RXD:  rsel_q <= rx_empty ? RSEL_ZERO : RSEL_FIFO;
          default:  rsel_q <= RSEL_ZERO;
        endcase
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RSEL_STAT: rdata = {{(WIDTH - 4){1'b0}}, stat_rd_q};
      RSEL_FIFO: rdata = rx_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbox_pair.sv
module mbox_pair #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [1:0]        a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [1:0]        b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);

  localparam int NCORE = 2;
  localparam int LVL_W = $clog2(DEPTH + 1);

  // per-core port side (index = core), per-queue side (index = sending core)
  logic [NCORE-1:0]             c_req, c_we, c_irq;
  logic [NCORE-1:0][1:0]        c_addr;
  logic [NCORE-1:0][DATA_W-1:0] c_wdata, c_rdata;
  logic [NCORE-1:0]             p_push, p_pop, p_wof, p_roe, p_clr;
  logic [NCORE-1:0][DATA_W-1:0] p_txd;
  logic [NCORE-1:0]             f_push, f_pop, f_full, f_empty;
  logic [NCORE-1:0][DATA_W-1:0] f_wdata, f_q;
  logic [NCORE-1:0][LVL_W-1:0]  f_level;

  assign c_req   = {b_req, a_req};
  assign c_we    = {b_we, a_we};
  assign c_addr  = {b_addr, a_addr};
  assign c_wdata = {b_wdata, a_wdata};
  assign a_rdata = c_rdata[0];
  assign b_rdata = c_rdata[1];
  assign a_irq   = c_irq[0];
  assign b_irq   = c_irq[1];

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    // queue g carries words from core g to core 1-g
    assign f_push[g]  = p_push[g];
    assign f_wdata[g] = p_txd[g];
    assign f_pop[g]   = p_pop[NCORE - 1 - g];

    mbox_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .LW(LVL_W)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (f_push[g]),
      .wdata (f_wdata[g]),
      .pop   (f_pop[g]),
      .full  (f_full[g]),
      .empty (f_empty[g]),
      .q     (f_q[g]),
      .level (f_level[g])
    );

    mbox_port #(.WIDTH(DATA_W)) u_port (
      .clk      (clk),
      .rst      (rst),
      .req      (c_req[g]),
      .we       (c_we[g]),
      .addr     (c_addr[g]),
      .wdata    (c_wdata[g]),
      .tx_full  (f_full[g]),
      .rx_empty (f_empty[NCORE - 1 - g]),
      .rx_q     (f_q[NCORE - 1 - g]),
      .tx_push  (p_push[g]),
      .tx_data  (p_txd[g]),
      .rx_pop   (p_pop[g]),
      .rdata    (c_rdata[g]),
      .irq      (c_irq[g]),
      .wof      (p_wof[g]),
      .roe      (p_roe[g]),
      .stat_clr (p_clr[g])
    );
  end

endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int LW     = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [1:0]            f_push,
  input logic [1:0]            f_pop,
  input logic [1:0]            f_full,
  input logic [1:0]            f_empty,
  input logic [1:0][LW-1:0]    f_level,
  input logic [1:0]            p_wof,
  input logic [1:0]            p_roe,
  input logic [1:0]            p_clr,
  input logic                  a_req,
  input logic                  a_we,
  input logic [DATA_W-1:0]     a_rdata,
  input logic                  a_irq,
  input logic                  b_irq
);

  for (genvar i = 0; i < 2; i++) begin : g_q
    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
      f_level[i] <= LW'(DEPTH));

    // R6
    full_discard_chk: assert property (@(posedge clk) disable iff (rst)
      (f_push[i] & f_full[i] & ~f_pop[i]) |=> $stable(f_level[i]));

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
      (f_pop[i] & f_empty[i] & ~f_push[i]) |=> f_empty[i]);

    // R6
    wof_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (p_wof[i] & ~p_clr[i]) |=> p_wof[i]);

    // R7
    roe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (p_roe[i] & ~p_clr[i]) |=> p_roe[i]);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      p_clr[i] |=> (!p_wof[i] && !p_roe[i]));
  end

  // R9
  irq_a_chk: assert property (@(posedge clk) disable iff (rst)
    a_irq == $past(~f_empty[1] | p_wof[0] | p_roe[0]));

  // R9
  irq_b_chk: assert property (@(posedge clk) disable iff (rst)
    b_irq == $past(~f_empty[0] | p_wof[1] | p_roe[1]));

  // R2
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_req & !a_we) |=> (a_rdata == '0));

endmodule

bind mbox_pair mbox_pair_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LW(LVL_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .f_push  (f_push),
  .f_pop   (f_pop),
  .f_full  (f_full),
  .f_empty (f_empty),
  .f_level (f_level),
  .p_wof   (p_wof),
  .p_roe   (p_roe),
  .p_clr   (p_clr),
  .a_req   (a_req),
  .a_we    (a_we),
  .a_rdata (a_rdata),
  .a_irq   (a_irq),
  .b_irq   (b_irq)
);

// File: tb/sim_mbox_pair.sv
module sim_mbox_pair;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 32;
  localparam int DEPTH      = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [1:0]    a_addr = 0, b_addr = 0;
  logic [DW-1:0] a_wdata = 0, b_wdata = 0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic          a_irq, b_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_pair #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  // reference model: queue 0 = A to B, queue 1 = B to A
  logic [DW-1:0] fq0[$];
  logic [DW-1:0] fq1[$];
  bit            m_wof[2];
  bit            m_roe[2];
  int            n_checks = 0;
  int            n_fail   = 0;
  string         cur      = "R1";
  bit            done     = 0;

  function automatic int qsize(int i);
    return (i == 0) ? fq0.size() : fq1.size();
  endfunction

  function automatic logic [DW-1:0] qfront(int i);
    return (i == 0) ? fq0[0] : fq1[0];
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock with both ports driven; model stepped and outputs compared
  task automatic cyc(input logic ar, input logic aw, input logic [1:0] aa, input logic [DW-1:0] ad,
                     input logic br, input logic bw, input logic [1:0] ba, input logic [DW-1:0] bd);
    logic          rq[2], wr[2];
    logic [1:0]    ad_i[2];
    logic [DW-1:0] wd[2];
    logic [DW-1:0] exp_rd[2];
    logic          exp_irq[2];
    bit            push_ok[2], pop_ok[2];
    a_req = ar; a_we = aw; a_addr = aa; a_wdata = ad;
    b_req = br; b_we = bw; b_addr = ba; b_wdata = bd;
    rq[0] = ar; wr[0] = aw; ad_i[0] = aa; wd[0] = ad;
    rq[1] = br; wr[1] = bw; ad_i[1] = ba; wd[1] = bd;
    for (int i = 0; i < 2; i++) begin
      bit vld, rdy;
      vld = qsize(1 - i) > 0;
      rdy = qsize(i) < DEPTH;
      exp_irq[i] = vld | m_wof[i] | m_roe[i];
      exp_rd[i]  = '0;
      push_ok[i] = 0;
      pop_ok[i]  = 0;
      if (rq[i] && !wr[i]) begin
        if (ad_i[i] == 2'd0) exp_rd[i] = {28'd0, m_roe[i], m_wof[i], rdy, vld};
        else if (ad_i[i] == 2'd2) begin
          if (vld) begin exp_rd[i] = qfront(1 - i); pop_ok[i] = 1; end
          else m_roe[i] = 1;
        end
      end else if (rq[i] && wr[i]) begin
        if (ad_i[i] == 2'd0) begin m_wof[i] = 0; m_roe[i] = 0; end
        else if (ad_i[i] == 2'd1) begin
          if (rdy) push_ok[i] = 1;
          else m_wof[i] = 1;
        end
      end
    end
    @(posedge clk);
    if (pop_ok[0]) void'(fq1.pop_front());
    if (pop_ok[1]) void'(fq0.pop_front());
    if (push_ok[0]) fq0.push_back(wd[0]);
    if (push_ok[1]) fq1.push_back(wd[1]);
    @(negedge clk);
    check({cur, " rdata A"}, a_rdata, exp_rd[0]);
    check({cur, " rdata B"}, b_rdata, exp_rd[1]);
    check({cur, " irq A"}, DW'(a_irq), DW'(exp_irq[0]));
    check({cur, " irq B"}, DW'(b_irq), DW'(exp_irq[1]));
  endtask

  task automatic idle();
    cyc(0, 0, 2'd0, '0, 0, 0, 2'd0, '0);
  endtask

  task automatic acc(input int core, input logic we, input logic [1:0] addr, input logic [DW-1:0] d);
    if (core == 0) cyc(1, we, addr, d, 0, 0, 2'd0, '0);
    else           cyc(0, 0, 2'd0, '0, 1, we, addr, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    cur = "R1";
    check("R1 irq A", DW'(a_irq), '0);
    check("R1 irq B", DW'(b_irq), '0);
    acc(0, 0, 2'd0, '0);
    acc(1, 0, 2'd0, '0);
    idle();

    // R3 R4: ordered transfer A to B
    cur = "R3";
    for (int k = 0; k < 3; k++) acc(0, 1, 2'd1, 32'hA000_0000 + k);
    cur = "R4";
    acc(1, 0, 2'd0, '0);
    idle();
    cur = "R3";
    for (int k = 0; k < 3; k++) acc(1, 0, 2'd2, '0);
    acc(1, 0, 2'd0, '0);

    // R5 R6: fill, then overflow
    cur = "R5";
    for (int k = 0; k < DEPTH; k++) acc(0, 1, 2'd1, 32'h5500_0000 + k);
    acc(0, 0, 2'd0, '0);
    cur = "R6";
    acc(0, 1, 2'd1, 32'hDEAD_BEEF);
    acc(0, 0, 2'd0, '0);
    idle();
    acc(0, 0, 2'd0, '0);
    cur = "R3";
    for (int k = 0; k < DEPTH; k++) acc(1, 0, 2'd2, '0);

    // R7: underflow on B, value 0 and sticky
    cur = "R7";
    acc(1, 0, 2'd2, '0);
    idle();
    acc(1, 0, 2'd0, '0);

    // R8: clear only the writer's flags
    cur = "R8";
    acc(1, 1, 2'd0, 32'hFFFF_FFFF);
    acc(1, 0, 2'd0, '0);
    acc(0, 0, 2'd0, '0);
    acc(0, 1, 2'd0, '0);
    acc(0, 0, 2'd0, '0);

    // R2: odd addresses
    cur = "R2";
    acc(0, 0, 2'd1, '0);
    acc(0, 0, 2'd3, '0);
    acc(1, 1, 2'd2, 32'h1234_5678);
    acc(1, 1, 2'd3, 32'h1234_5678);
    acc(0, 0, 2'd0, '0);
    acc(0, 0, 2'd2, '0);
    acc(0, 0, 2'd0, '0);
    acc(0, 1, 2'd0, '0);

    // R10: both directions at once
    cur = "R10";
    for (int k = 0; k < 4; k++) cyc(1, 1, 2'd1, 32'hA1 + k, 1, 1, 2'd1, 32'hB1 + k);
    for (int k = 0; k < 4; k++) cyc(1, 0, 2'd2, '0, 1, 0, 2'd2, '0);
    cyc(1, 1, 2'd1, 32'hC0, 0, 0, 2'd0, '0);
    cyc(1, 1, 2'd1, 32'hC1, 1, 0, 2'd2, '0);
    cyc(0, 0, 2'd0, '0, 1, 0, 2'd2, '0);

    // R11: collisions at full and at empty
    cur = "R11";
    for (int k = 0; k < DEPTH; k++) acc(0, 1, 2'd1, 32'h7700_0000 + k);
    cyc(1, 1, 2'd1, 32'hBAD0_0001, 1, 0, 2'd2, '0);
    acc(0, 0, 2'd0, '0);
    for (int k = 0; k < DEPTH - 1; k++) acc(1, 0, 2'd2, '0);
    cyc(1, 1, 2'd1, 32'h600D_0001, 1, 0, 2'd2, '0);
    acc(1, 0, 2'd0, '0);
    acc(1, 0, 2'd2, '0);
    acc(0, 1, 2'd0, '0);
    acc(1, 1, 2'd0, '0);

    // R9 and R10: mixed random traffic, model compared every clock
    cur = "R9";
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] aa, ba;
      logic       aw, bw, ar, br;
      ar = ($urandom_range(3) != 0);
      br = ($urandom_range(3) != 0);
      aw = $urandom_range(1);
      bw = $urandom_range(1);
      aa = ($urandom_range(9) == 0) ? 2'd0 : ($urandom_range(1) ? 2'd1 : 2'd2);
      ba = ($urandom_range(9) == 0) ? 2'd0 : ($urandom_range(1) ? 2'd1 : 2'd2);
      cyc(ar, aw, aa, $urandom, br, bw, ba, $urandom);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule